// File: doc/BRIEF.md
# Three-Wire Synthesizer Word Loader

This block receives programming words for a frequency synthesizer over a three-line serial link made of data, clock and enable lines. While enable is high, each falling edge of the serial clock shifts one data bit into a 19-bit holding register, and a pulse counter tracks how many edges arrived. When enable falls, the word is copied into the output latches. This happens only if the window held exactly 19 pulses. Any other count drops the word and leaves the latched values as they were.

A latched word supplies a 15-bit division ratio and four switch-port bits. In this bus mode the block also drives two fixed outputs. The shared switch/lock output carries the loop's lock flag, and the charge-pump current select is held at its high setting. All serial lines are sampled by the system clock, which must run fast enough to see every level of the serial signals.

Top module: `tw_loader`

## Requirements
- R1: After a synchronous active-high reset, `scale_o` and `port_o` are zero.
- R2: On each falling edge of `ser_clk_i` seen while `ser_en_i` is high, the level of `ser_dat_i` is shifted in. The first bit of a word is its most significant bit.
- R3: Falling edges of `ser_clk_i` while `ser_en_i` is low are neither shifted nor counted.
- R4: The word uses this bit order. The first four bits sent are the port bits for switches 7, 6, 5 and 4, which appear on `port_o[3]` down to `port_o[0]`. The next 15 bits are the division ratio, sent MSB first, and appear on `scale_o[14:0]`.
- R5: When `ser_en_i` falls after exactly 19 counted pulses, the word is latched and shows on the outputs within four system clocks of that fall.
- R6: When `ser_en_i` falls after any other pulse count, including 0, 18, 20 and long bursts, the word is discarded and both outputs keep their previous values. The pulse counter saturates at 20.
- R7: The pulse counter restarts from zero at each rising edge of `ser_en_i`, so pulses from an earlier window never add to a new one.
- R8: The outputs do not change while enable is still high, even after 19 pulses.
- R9: `lock_sw_o` equals `lock_i`, with 1 meaning the output is on (in lock).
- R10: `cp_high_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat_i | input | 1 | Serial data |
| ser_en_i | input | 1 | Serial enable; a word is framed by one high window |
| lock_i | input | 1 | Lock flag from the loop detector |
| scale_o | output | 15 | Latched division ratio |
| port_o | output | 4 | Latched switch bits, [3] = SW7 down to [0] = SW4 |
| lock_sw_o | output | 1 | Shared switch/lock output; 1 = on |
| cp_high_o | output | 1 | Charge-pump high-current select, fixed high |

## Verification
An off-by-one pulse counter shows up within a few cycles of the enable fall: a 19-pulse word is rejected, or an 18-pulse or 20-pulse word changes the outputs. A counter that fails to clear at the rising edge of enable corrupts the second of two back-to-back windows. A wrong shift direction or a stray shift while enable is low shows as a scrambled `scale_o` or `port_o` at the next accepted word. That word is compared bit for bit against the pattern that was sent.

// File: rtl/tw_loader_pkg.sv
package tw_loader_pkg;

    localparam int unsigned SCALE_W = 15;
    localparam int unsigned PORT_W  = 4;

    typedef struct packed {
        logic [PORT_W-1:0]  port;
        logic [SCALE_W-1:0] scale;
    } tw_word_t;

    function automatic tw_word_t split_word(input logic [PORT_W+SCALE_W-1:0] raw);
        tw_word_t w;
        w.port  = raw[PORT_W+SCALE_W-1:SCALE_W];
        w.scale = raw[SCALE_W-1:0];
        return w;
    endfunction

endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic q_now;
    logic q_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_now <= 1'b0;
            q_old <= 1'b0;
        end else begin
            q_now <= din;
            q_old <= q_now;
        end
    end

    assign lvl  = q_now;
    assign rise = q_now & ~q_old;
    assign fall = ~q_now & q_old;
endmodule

// File: rtl/tw_shift_counter.sv
module tw_shift_counter #(
    parameter int unsigned WORD_W = 19,
    localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              shift,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift) begin
            word <= {word[WORD_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (restart) begin
            count <= shift ? CNT_W'(1) : '0;
        end else if (shift && count != CNT_SAT) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tw_loader.sv
module tw_loader
    import tw_loader_pkg::*;
#(
    parameter int unsigned SF_W  = SCALE_W,
    parameter int unsigned PRT_W = PORT_W,
    localparam int unsigned WORD_W = SF_W + PRT_W,
    localparam int unsigned CNT_W  = $clog2(WORD_W + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_en_i,
    input  logic             lock_i,
    output logic [SF_W-1:0]  scale_o,
    output logic [PRT_W-1:0] port_o,
    output logic             lock_sw_o,
    output logic             cp_high_o
);
    logic sclk_lvl, sclk_rise, sclk_fall;
    logic en_lvl, en_rise, en_fall;
    logic dat_lvl, dat_rise, dat_fall;
    logic [WORD_W-1:0] sr_word;
    logic [CNT_W-1:0]  bit_cnt;
    logic              take;

    tw_edge_sync u_sclk (.clk(clk), .rst(rst), .din(ser_clk_i),
                         .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));
    tw_edge_sync u_en   (.clk(clk), .rst(rst), .din(ser_en_i),
                         .lvl(en_lvl), .rise(en_rise), .fall(en_fall));
    tw_edge_sync u_dat  (.clk(clk), .rst(rst), .din(ser_dat_i),
                         .lvl(dat_lvl), .rise(dat_rise), .fall(dat_fall));

    tw_shift_counter #(.WORD_W(WORD_W)) u_sr (
        .clk(clk), .rst(rst),
        .restart(en_rise),
        .shift(sclk_fall & en_lvl),
        .bit_in(dat_lvl),
        .word(sr_word),
        .count(bit_cnt)
    );

    assign take = en_fall && (bit_cnt == CNT_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_o <= '0;
            port_o  <= '0;
        end else if (take) begin
            port_o  <= sr_word[WORD_W-1:SF_W];
            scale_o <= sr_word[SF_W-1:0];
        end
    end

    assign lock_sw_o = lock_i;
    assign cp_high_o = 1'b1;

    logic unused_edges;
    assign unused_edges = sclk_lvl ^ sclk_rise ^ dat_rise ^ dat_fall;
endmodule

// File: rtl/tw_loader_chk.sv
module tw_loader_chk #(
    parameter int unsigned WORD_W = 19,
    parameter int unsigned SF_W   = 15,
    localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              en_q,
    input logic              en_rise,
    input logic              en_fall,
    input logic              clk_fall,
    input logic [CNT_W-1:0]  cnt,
    input logic [WORD_W-1:0] sr_word,
    input logic [SF_W-1:0]   scale_o,
    input logic [WORD_W-SF_W-1:0] port_o
);
    // R3: no shift while enable is low
    a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> $stable(sr_word));

    // R6: counter never passes saturation
    a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W + 1));

    // R7: counter restarts on enable rise
    a_r7_cnt_restart: assert property (@(posedge clk) disable iff (rst)
        (en_rise && !clk_fall) |=> cnt == '0);

    // R5: exact count latches the shifted word
    a_r5_accept_word: assert property (@(posedge clk) disable iff (rst)
        (en_fall && cnt == CNT_W'(WORD_W)) |=> {port_o, scale_o} == $past(sr_word));

    // R6: wrong count keeps outputs
    a_r6_reject_word: assert property (@(posedge clk) disable iff (rst)
        (en_fall && cnt != CNT_W'(WORD_W)) |=> ($stable(scale_o) && $stable(port_o)));

    // R8: outputs move only right after an enable fall
    a_r8_change_only_on_fall: assert property (@(posedge clk) disable iff (rst)
        !en_fall |=> ($stable(scale_o) && $stable(port_o)));
endmodule

bind tw_loader tw_loader_chk #(.WORD_W(WORD_W), .SF_W(SF_W)) u_chk (
    .clk(clk), .rst(rst), .en_q(en_lvl), .en_rise(en_rise), .en_fall(en_fall),
    .clk_fall(sclk_fall), .cnt(bit_cnt), .sr_word(sr_word),
    .scale_o(scale_o), .port_o(port_o)
);

// File: tb/tw_loader_test.sv
module tw_loader_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_en_i = 1'b0, lock_i = 1'b0;
    logic [14:0] scale_o;
    logic [3:0]  port_o;
    logic lock_sw_o, cp_high_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tw_loader uut (.clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
                   .ser_en_i(ser_en_i), .lock_i(lock_i), .scale_o(scale_o),
                   .port_o(port_o), .lock_sw_o(lock_sw_o), .cp_high_o(cp_high_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one serial pulse with bit b; data stable across the falling edge
    task automatic pulse(input logic b);
        ser_dat_i = b;
        wait_clk(2);
        ser_clk_i = 1'b1;
        wait_clk(2);
        ser_clk_i = 1'b0;
        wait_clk(2);
    endtask

    // frame of npulse pulses; first 19 come from w MSB first, extras are 0
    task automatic frame(input logic [18:0] w, input int npulse, input bit drop_en);
        ser_en_i = 1'b1;
        wait_clk(3);
        for (int i = 0; i < npulse; i++) pulse(i < 19 ? w[18-i] : 1'b0);
        if (drop_en) begin
            wait_clk(2);
            ser_en_i = 1'b0;
            wait_clk(5);
        end
    endtask

    task automatic check_out(input string req, input logic [18:0] exp);
        check(req, {13'd0, port_o, scale_o}, {13'd0, exp});
    endtask

    task automatic t_reset;
        check_out("R1 reset", 19'd0);
        check("R10 cp_high", 32'(cp_high_o), 32'd1);
    endtask

    task automatic t_accept;
        logic [18:0] w = {4'b1010, 15'h5A3C};
        frame(w, 19, 1'b1);
        check_out("R2 R4 R5 accept", w);
        check("R4 port SW7 bit", 32'(port_o[3]), 32'd1);
        w = {4'b0101, 15'h7FFF};
        frame(w, 19, 1'b1);
        check_out("R5 accept second", w);
    endtask

    task automatic t_reject;
        logic [18:0] keep = {4'b0101, 15'h7FFF};
        frame(19'h12345, 18, 1'b1);
        check_out("R6 reject 18", keep);
        frame(19'h0ABCD, 20, 1'b1);
        check_out("R6 reject 20", keep);
        frame(19'h11111, 0, 1'b1);
        check_out("R6 reject 0", keep);
        frame(19'h2AAAA, 40, 1'b1);
        check_out("R6 reject long burst", keep);
    endtask

    task automatic t_ignore_low;
        logic [18:0] w = {4'b0011, 15'h0001};
        for (int i = 0; i < 5; i++) pulse(1'b1);
        check_out("R3 no effect while low", {4'b0101, 15'h7FFF});
        frame(w, 19, 1'b1);
        check_out("R3 stray pulses not counted", w);
    endtask

    task automatic t_restart;
        logic [18:0] w = {4'b1100, 15'h2468};
        frame(19'h7FFFF, 10, 1'b1);
        frame(w, 19, 1'b1);
        check_out("R7 restart per window", w);
    endtask

    task automatic t_hold_until_fall;
        logic [18:0] w = {4'b1001, 15'h1357};
        frame(w, 19, 1'b0);
        wait_clk(5);
        check_out("R8 no change while enable high", {4'b1100, 15'h2468});
        ser_en_i = 1'b0;
        wait_clk(4);
        check_out("R5 latch after fall", w);
    endtask

    task automatic t_lock;
        lock_i = 1'b1;
        wait_clk(1);
        check("R9 lock on", 32'(lock_sw_o), 32'd1);
        lock_i = 1'b0;
        wait_clk(1);
        check("R9 lock off", 32'(lock_sw_o), 32'd0);
        check("R10 cp_high held", 32'(cp_high_o), 32'd1);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_accept();
        t_reject();
        t_ignore_low();
        t_restart();
        t_hold_until_fall();
        t_lock();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #900000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule